// File: doc/BRIEF.md
# Two-Inverter Multi-Input Complementer

This block returns the bitwise complement of a parallel input vector while containing only two explicit NOT gates. Every other gate is an AND or an OR. The trick is to find how many input bits are set and carry that count as a few binary signals, called count leads here. Only those leads are ever inverted. A one-hot "exactly m bits set" term is then built from the leads and their complements. Each output bit asks, with monotone logic only, whether the other inputs already account for the whole count. If they do, the bit's own input must be zero.

A three-bit count needs no more than the two NOT gates. A seven-bit count needs three complemented leads. In this design those three complements come from a second, three-input copy of the same circuit instead of from three NOT gates. That second copy takes the seven-input stage's own leads as its inputs, which closes a loop. Each of the three leads is therefore held in a flip-flop. The leads form a chain: the weight-4 lead needs no complement, the weight-2 lead needs the weight-4 complement, and the weight-1 lead needs both. As a result, the registered loop reaches the right value after at most three rising clock edges, and the three-input-only mode stays purely combinational.

A parameter chooses between the three-input mode and the cascaded seven-input mode.

Top module: `twoinv_complementer`

## Requirements
- R1: With WIDTH=7 and `x_i` held constant, `z_o` equals the bitwise complement of `x_i` when sampled after the third rising `clk` edge with `rst_n` high. This holds for all 128 input patterns, whatever pattern came before.
- R2: With WIDTH=7 and `x_i` still held, `z_o` keeps that complemented value on every later rising edge. It never oscillates.
- R3: With WIDTH=7, once the count leads have settled for one pattern, any change of `x_i` to another pattern with the same number of ones gives `z_o` equal to the new complement with no clock edge in between.
- R4: With WIDTH=7, a rising edge with `rst_n` low clears all three count leads to zero. That is the correct lead value for an all-zero input. With `x_i` all zeros, `z_o` is therefore all ones after such an edge, and it stays all ones after `rst_n` is released.
- R5: With WIDTH=3, `z_o` equals the bitwise complement of `x_i` for all eight patterns, combinationally, with no clock edge needed.
- R6: With WIDTH=3, `clk` and `rst_n` have no effect: `z_o` is still the complement of `x_i` while `rst_n` is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the count-lead registers (used when WIDTH=7) |
| rst_n | input | 1 | Synchronous active-low reset of the count leads |
| x_i | input | WIDTH | Vector to be complemented |
| z_o | output | WIDTH | Bitwise complement of `x_i` |

## Verification
A wrong count lead shows up as an exact-count term that names the wrong population. It does not corrupt a single bit. Instead it makes whole groups of output bits wrong together: every bit whose input is zero, or every bit whose input is one, flips at once. A lead that is stuck or settles late would show at the ports on the third edge after an input change. A lead that settles but does not hold would show on the edges that follow. The same-count transitions expose any output term that leans on the registers instead of on the live inputs, and they do so before the next edge.

// File: rtl/cmp_pkg.sv
// Package: shared sizes for the two-inverter complementer.
// Assumes: only the three-input and seven-input arrangements are supported.
package cmp_pkg;
    localparam int unsigned BASE_W    = 3;   // width handled by the core stage
    localparam int unsigned CASCADE_W = 7;   // width handled by the cascaded stage
    localparam int unsigned LEAD_W    = 3;   // count leads in the cascaded stage
    localparam int unsigned RUN_W     = 2;   // saturating run counter in the checker
endpackage

// File: rtl/cmp_threshold.sv
// Module: cmp_threshold
// Computes, for every k in 1..W, whether at least k bits of v_i are set.
// Built as a running-count table of AND and OR gates only (monotone).
// Assumes W >= 2.
module cmp_threshold #(
    parameter int unsigned W = 3
) (
    input  logic [W-1:0] v_i,
    output logic [W:1]   ge_o
);
    // acc[i][k]: at least k ones among v_i[i:0]
    logic [W-1:0][W:1] acc;

    for (genvar i = 0; i < W; i++) begin : g_row
        if (i == 0) begin : g_first
            // first row: only one bit seen so far
            assign acc[0] = {{(W-1){1'b0}}, v_i[0]};
        end else begin : g_next
            // reaching one needs either an earlier one or this bit
            assign acc[i][1] = acc[i-1][1] | v_i[i];
            for (genvar k = 2; k <= W; k++) begin : g_col
                // reaching k: already there, or k-1 plus this bit
                assign acc[i][k] = acc[i-1][k] | (acc[i-1][k-1] & v_i[i]);
            end
        end
    end

    assign ge_o = acc[W-1];
endmodule

// File: rtl/cmp_not_cell.sv
// Module: cmp_not_cell
// The single inverting primitive of the project. The design places exactly
// two instances of it. No other negation appears in the design RTL.
module cmp_not_cell (
    input  logic a_i,
    output logic y_o
);
    assign y_o = ~a_i;
endmodule

// File: rtl/cmp_core3.sv
// Module: cmp_core3
// Complements three signals using two cmp_not_cell instances plus AND/OR.
// The inverted signals are the two bits of the population count.
// Purely combinational. Assumes nothing about the inputs.
module cmp_core3 (
    input  logic [2:0] a_i,
    output logic [2:0] na_o
);
    logic [3:1] ge;
    logic       high_lead;     // weight-2 bit of the count
    logic       low_lead;      // weight-1 bit of the count
    logic       high_n;
    logic       low_n;
    logic       cnt0, cnt1, cnt2;

    cmp_threshold #(.W(3)) u_thr (.v_i(a_i), .ge_o(ge));

    // weight-2 bit is simply "two or more set"
    assign high_lead = ge[2];
    cmp_not_cell u_inv_high (.a_i(high_lead), .y_o(high_n));

    // weight-1 bit: one set below two, or all three
    assign low_lead = (ge[1] & high_n) | ge[3];
    cmp_not_cell u_inv_low (.a_i(low_lead), .y_o(low_n));

    // exact-count terms from leads and thresholds only
    assign cnt0 = high_n & low_n;
    assign cnt1 = high_n & ge[1];
    assign cnt2 = low_n  & ge[2];

    for (genvar i = 0; i < 3; i++) begin : g_out
        localparam int unsigned P = (i + 1) % 3;
        localparam int unsigned Q = (i + 2) % 3;
        // bit i is zero exactly when the other two account for the whole count
        assign na_o[i] = cnt0
                       | (cnt1 & (a_i[P] | a_i[Q]))
                       | (cnt2 & (a_i[P] & a_i[Q]));
    end
endmodule

// File: rtl/cmp_core7.sv
// Module: cmp_core7
// Complements seven signals. The three count leads are complemented by a
// cmp_core3 instance. The loop through it is cut by registering the leads.
// The leads settle in at most three edges: weight 4, then 2, then 1.
// Assumes x_i is held for three edges before z_o is relied upon.
// Synchronous active-low reset clears the leads.
module cmp_core7
    import cmp_pkg::*;
#(
    parameter int unsigned W  = CASCADE_W,
    parameter int unsigned LW = LEAD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] x_i,
    output logic [W-1:0] z_o
);
    logic [W:1]    ge;
    logic [LW-1:0] lead_q;   // bit 2 = weight 4, bit 0 = weight 1
    logic [LW-1:0] lead_d;
    logic [LW-1:0] lead_n;
    logic [W-1:0]  exact;

    cmp_threshold #(.W(W)) u_thr (.v_i(x_i), .ge_o(ge));

    // complements of the registered leads via the nested three-input stage
    cmp_core3 u_lead_inv (.a_i(lead_q), .na_o(lead_n));

    // next lead values: each uses only complements of higher-weight leads
    always_comb begin
        lead_d[2] = ge[4];
        lead_d[1] = (ge[2] & lead_n[2]) | ge[6];
        lead_d[0] = (ge[1] & lead_n[2] & lead_n[1])
                  | (ge[3] & lead_n[2])
                  | (ge[5] & lead_n[1] & ge[4])
                  | ge[7];
    end

    // lead registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) lead_q <= '0;
        else        lead_q <= lead_d;
    end

    // one-hot exact-count decode from leads and their complements
    for (genvar m = 0; m < W; m++) begin : g_exact
        logic [LW-1:0] lit;
        for (genvar j = 0; j < LW; j++) begin : g_lit
            if (((m >> j) % 2) == 1) begin : g_pos
                assign lit[j] = lead_q[j];
            end else begin : g_neg
                assign lit[j] = lead_n[j];
            end
        end
        assign exact[m] = &lit;
    end

    // each output: count fully explained by the other six inputs
    for (genvar i = 0; i < W; i++) begin : g_out
        logic [W-2:0] oth;
        logic [W-1:1] oth_ge;
        for (genvar j = 0; j < W - 1; j++) begin : g_oth
            if (j < i) begin : g_lo
                assign oth[j] = x_i[j];
            end else begin : g_hi
                assign oth[j] = x_i[j+1];
            end
        end
        cmp_threshold #(.W(W-1)) u_oth (.v_i(oth), .ge_o(oth_ge));
        assign z_o[i] = exact[0] | (|(exact[W-1:1] & oth_ge));
    end
endmodule

// File: rtl/twoinv_complementer.sv
// Module: twoinv_complementer (top)
// Outputs the bitwise complement of x_i using two NOT gates in total.
// WIDTH=3 selects the combinational core. WIDTH=7 selects the cascaded
// stage with registered count leads. Other widths are rejected.
module twoinv_complementer
    import cmp_pkg::*;
#(
    parameter int unsigned WIDTH = CASCADE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] x_i,
    output logic [WIDTH-1:0] z_o
);
    if (WIDTH == BASE_W) begin : g_base
        cmp_core3 u_core (.a_i(x_i), .na_o(z_o));
    end else if (WIDTH == CASCADE_W) begin : g_casc
        cmp_core7 u_core (.clk(clk), .rst_n(rst_n), .x_i(x_i), .z_o(z_o));
    end else begin : g_bad
        $error("twoinv_complementer: unsupported WIDTH");
    end
endmodule

// File: rtl/twoinv_chk.sv
// Module: twoinv_chk
// Port-level assertions for twoinv_complementer, attached by bind.
// Tracks how many edges x_i has been held since it last changed or reset ended.
module twoinv_chk
    import cmp_pkg::*;
#(
    parameter int unsigned WIDTH = CASCADE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] x_i,
    input logic [WIDTH-1:0] z_o
);
    logic [WIDTH-1:0] prev_x_q;
    logic [RUN_W-1:0] run_q;
    logic             fresh_q;
    logic             rstlow_q;

    // input history for the settle window
    always_ff @(posedge clk) begin
        prev_x_q <= x_i;
        rstlow_q <= !rst_n;
        if (!rst_n) begin
            run_q   <= '0;
            fresh_q <= 1'b1;
        end else begin
            fresh_q <= 1'b0;
            if (fresh_q || x_i != prev_x_q) run_q <= '0;
            else if (run_q != '1)           run_q <= run_q + 1'b1;
        end
    end

    // R1
    settle_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fresh_q && run_q >= 2 && x_i == prev_x_q) |-> (z_o == ~x_i));

    // R2
    hold_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fresh_q && run_q == '1 && x_i == prev_x_q) |-> $stable(z_o));

    // R4
    rst_clear_chk: assert property (@(posedge clk)
        (rstlow_q && x_i == '0) |-> (z_o == '1));

    if (WIDTH == BASE_W) begin : g_base_chk
        // R5
        always_comb begin
            if (!$isunknown(x_i)) begin
                base_comb_chk: assert (z_o == ~x_i);
            end
        end
    end
endmodule

bind twoinv_complementer twoinv_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .x_i(x_i), .z_o(z_o)
);

// File: tb/tb_twoinv_complementer.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_twoinv_complementer;
    localparam int CLK_PERIOD   = 10;
    localparam int WATCHDOG_CYC = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] x7 = '0;
    logic [2:0] x3 = '0;
    logic [6:0] z7;
    logic [2:0] z3;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twoinv_complementer #(.WIDTH(7)) dut  (.clk(clk), .rst_n(rst_n), .x_i(x7), .z_o(z7));
    twoinv_complementer #(.WIDTH(3)) dut3 (.clk(clk), .rst_n(rst_n), .x_i(x3), .z_o(z3));

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // R4: reset clears leads; all-zero input gives all-ones output
    task automatic t_reset_state();
        rst_n = 1'b0;
        x7 = '0;
        x3 = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R4 reset, zero input", z7, 7'h7F);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R4 after release", z7, 7'h7F);
    endtask

    // R1 / R2: every seven-bit pattern, settled then held
    task automatic t_exhaustive7();
        for (int p = 0; p < 128; p++) begin
            @(negedge clk);
            x7 = 7'(p);
            repeat (3) @(posedge clk);
            @(negedge clk);
            check("R1 settle", z7, ~7'(p));
            repeat (2) @(posedge clk);
            @(negedge clk);
            check("R2 hold", z7, ~7'(p));
        end
    endtask

    // R1: worst-case swings between extremes
    task automatic t_swing7();
        logic [6:0] pats [4] = '{7'h7F, 7'h00, 7'h55, 7'h2A};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            x7 = pats[i];
            repeat (3) @(posedge clk);
            @(negedge clk);
            check("R1 swing", z7, ~pats[i]);
        end
    endtask

    // R3: same population count, no edge needed
    task automatic t_same_count();
        logic [6:0] from_p [4] = '{7'b0000111, 7'b0111111, 7'b0000001, 7'b1100110};
        logic [6:0] to_p   [4] = '{7'b1010100, 7'b1111110, 7'b1000000, 7'b0011011};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            x7 = from_p[i];
            repeat (4) @(posedge clk);
            @(negedge clk);
            x7 = to_p[i];
            #1;
            check("R3 same count", z7, ~to_p[i]);
        end
    endtask

    // R5: three-input mode, combinational
    task automatic t_mode3();
        for (int p = 0; p < 8; p++) begin
            x3 = 3'(p);
            #1;
            check("R5 comb", {4'b0, z3}, {4'b0, ~3'(p)});
        end
    endtask

    // R6: three-input mode ignores reset and clock
    task automatic t_mode3_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int p = 7; p >= 0; p--) begin
            x3 = 3'(p);
            @(posedge clk);
            #1;
            check("R6 reset ignored", {4'b0, z3}, {4'b0, ~3'(p)});
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset_state();
        t_mode3();
        t_exhaustive7();
        t_swing7();
        t_same_count();
        t_mode3_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule